// File: doc/BRIEF.md
# NAND Page Data Register and Storage Array

This block holds the byte-wide data register of a small NAND-style memory together with a storage array of pages. Each page carries a spare region whose size is one thirty-second of the page size. A command front end decodes the bus cycles and drives this block with two kinds of input. The first kind is operation strobes: start a program load, fetch a page for reading, commit the register to a page, fetch a page for copyback editing, and erase a block. The second kind is byte-level traffic: data-in writes and data-out read strobes.

Reads are served from the register, starting at the column plus a pointer offset. When the register runs dry during a read session, the next page is fetched on its own. Programming can only clear bits. Erase returns a whole aligned block to 0xFF. An operation that targets a page index outside the array has no effect.

Top module: `nand_page_unit`

## Requirements
- R1: After reset, every array byte reads 0xFF, `dout_o` is the idle value 0x00 and `done_o` is low.
- R2: A page row is PAGE_BYTES plus PAGE_BYTES/32 spare bytes (66 with defaults). After a read that starts at column 0 of the last page, exactly that many bytes come out, and then the idle value 0x00.
- R3: After `op_start_i`, the register is filled with 0xFF and each accepted data-in byte is appended at the next position. Bytes beyond one full row are dropped.
- R4: A data-in byte is accepted only when `din_valid_i` is high and `ce_ni`, `cle_i` and `ale_i` are all low.
- R5: `op_prog_i` ANDs the register into the addressed page. `done_o` is high in the cycle after the strobe, for one cycle.
- R6: `op_copy_i` loads the addressed page into the register. Data-in bytes are then written at the column in `addr_i`, but only when that column is below the row size. A later `op_prog_i` writes the edited row to any page.
- R7: `op_load_i` and the first read strobe start output at column plus `ptr_off_i` and give row-size-minus-start bytes. A start at or past the row size gives only the idle value.
- R8: A read strobe with `ce_ni` high returns the idle value and does not advance the read position.
- R9: Within a read session, a read strobe after the last byte loads the following page and returns its byte 0.
- R10: `op_erase_i` aligns the page index down to a multiple of PAGES_PER_BLK and sets every byte of those pages to 0xFF. `done_o` pulses in the next cycle.
- R11: A load, copy, program or erase whose page index is NUM_PAGES or more changes nothing, raises no `done_o`, and reads give the idle value.
- R12: `addr_i` holds the column in bits [COL_W-1:0] (16 by default) and the page index in the bits above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch phase; blocks data-in |
| ale_i | input | 1 | Address latch phase; blocks data-in |
| din_valid_i | input | 1 | Data-in byte strobe |
| din_i | input | 8 | Data-in byte |
| rd_strobe_i | input | 1 | Data-out read strobe |
| addr_i | input | ROW_W+COL_W | Page index (high) and column (low) |
| ptr_off_i | input | COL_W | Offset added to the column for reads |
| op_start_i | input | 1 | Begin program load |
| op_load_i | input | 1 | Fetch page for reading |
| op_prog_i | input | 1 | Commit register to page |
| op_copy_i | input | 1 | Fetch page for copyback editing |
| op_erase_i | input | 1 | Erase the block containing the page |
| dout_o | output | 8 | Read data byte, registered |
| done_o | output | 1 | One-cycle pulse after program or erase |

## Verification
The hardest state to reach from the ports is the end of a read window. At that point the remaining count is zero while the session is still live, so the next strobe must fetch the following page and must not restart at the addressed column. Table-driven windows with different column and offset pairs each read exactly their expected byte count and then one more strobe. That extra strobe lands on the page boundary, on the spare region, and on the array's last page, where the result must be idle.

// File: rtl/nand_page_pkg.sv
package nand_page_pkg;
  typedef enum logic {FILL_APPEND = 1'b0, FILL_COLUMN = 1'b1} fill_mode_e;
  localparam logic [7:0] IDLE_BYTE   = 8'h00;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  function automatic int spare_of(int page_bytes);
    return page_bytes / 32;
  endfunction
endpackage

// File: rtl/nand_page_array.sv
module nand_page_array
  import nand_page_pkg::*;
#(
  parameter int NUM_PAGES     = 8,
  parameter int PAGES_PER_BLK = 4,
  parameter int ROW_BYTES     = 66,
  parameter int PW            = $clog2(NUM_PAGES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] rd_page_i,
  output logic [7:0]    rd_row_o [ROW_BYTES],
  input  logic          prog_en_i,
  input  logic [PW-1:0] prog_page_i,
  input  logic [7:0]    prog_row_i [ROW_BYTES],
  input  logic          erase_en_i,
  input  logic [PW-1:0] erase_page_i
);
  logic [7:0] mem [NUM_PAGES][ROW_BYTES];
  logic [NUM_PAGES-1:0] pg_erase, pg_prog;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_dec
    assign pg_erase[g] = erase_en_i &&
                         (int'(erase_page_i) / PAGES_PER_BLK == g / PAGES_PER_BLK);
    assign pg_prog[g]  = prog_en_i && (prog_page_i == PW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int b = 0; b < ROW_BYTES; b++) mem[p][b] <= ERASED_BYTE;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (pg_erase[p]) begin
          for (int b = 0; b < ROW_BYTES; b++) mem[p][b] <= ERASED_BYTE;
        end else if (pg_prog[p]) begin
          // bits can only go 1 -> 0
          for (int b = 0; b < ROW_BYTES; b++) mem[p][b] <= mem[p][b] & prog_row_i[b];
        end
      end
    end
  end

  assign rd_row_o = mem[rd_page_i];
endmodule

// File: rtl/nand_page_buffer.sv
module nand_page_buffer
  import nand_page_pkg::*;
#(
  parameter int ROW_BYTES = 66,
  parameter int IW        = $clog2(ROW_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic [7:0]    load_row_i [ROW_BYTES],
  input  logic          append_i,
  input  logic          col_wr_i,
  input  logic [IW-1:0] col_idx_i,
  input  logic [7:0]    byte_i,
  output logic [7:0]    buf_o [ROW_BYTES],
  output logic [IW-1:0] fill_o
);
  logic [7:0]    row_q [ROW_BYTES];
  logic [IW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < ROW_BYTES; b++) row_q[b] <= ERASED_BYTE;
      fill_q <= '0;
    end else if (clear_i) begin
      for (int b = 0; b < ROW_BYTES; b++) row_q[b] <= ERASED_BYTE;
      fill_q <= '0;
    end else if (load_i) begin
      row_q  <= load_row_i;
      fill_q <= '0;
    end else if (append_i && fill_q < IW'(ROW_BYTES)) begin
      row_q[fill_q] <= byte_i;
      fill_q        <= fill_q + 1'b1;
    end else if (col_wr_i) begin
      row_q[col_idx_i] <= byte_i;
    end
  end

  assign buf_o  = row_q;
  assign fill_o = fill_q;
endmodule

// File: rtl/nand_page_unit.sv
module nand_page_unit
  import nand_page_pkg::*;
#(
  parameter int PAGE_BYTES    = 64,
  parameter int NUM_PAGES     = 8,
  parameter int PAGES_PER_BLK = 4,
  parameter int COL_W         = 16,
  parameter int ROW_W         = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ce_ni,
  input  logic                   cle_i,
  input  logic                   ale_i,
  input  logic                   din_valid_i,
  input  logic [7:0]             din_i,
  input  logic                   rd_strobe_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [COL_W-1:0]       ptr_off_i,
  input  logic                   op_start_i,
  input  logic                   op_load_i,
  input  logic                   op_prog_i,
  input  logic                   op_copy_i,
  input  logic                   op_erase_i,
  output logic [7:0]             dout_o,
  output logic                   done_o
);
  localparam int ROW_BYTES = PAGE_BYTES + spare_of(PAGE_BYTES);
  localparam int IW        = $clog2(ROW_BYTES + 1);
  localparam int PW        = $clog2(NUM_PAGES);
  localparam int SW        = COL_W + 1;
  localparam int RW1       = ROW_W + 1;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row_full;
  assign col      = addr_i[COL_W-1:0];
  assign row_full = addr_i[ROW_W+COL_W-1:COL_W];

  fill_mode_e    mode_q;
  logic          seq_q;
  logic [ROW_W-1:0] rd_row_q;
  logic [IW-1:0] ptr_q, rem_q, fill_cnt;
  logic [7:0]    arr_row [ROW_BYTES];
  logic [7:0]    buf_row [ROW_BYTES];

  logic any_op, rd_fire, din_fire, use_next, row_ok, sel_ok, start_ok, do_load;
  logic [RW1-1:0] sel_row;
  logic [SW-1:0]  ld_start;
  logic [IW-1:0]  ld_idx;

  assign any_op   = op_start_i | op_load_i | op_prog_i | op_copy_i | op_erase_i;
  assign rd_fire  = rd_strobe_i && !ce_ni && !any_op;
  assign din_fire = din_valid_i && !ce_ni && !cle_i && !ale_i;
  // continuing a session: empty register fetches the following page at column 0
  assign use_next = seq_q && rd_fire && rem_q == '0;
  assign sel_row  = use_next ? RW1'(rd_row_q) + 1'b1 : RW1'(row_full);
  assign ld_start = use_next ? '0 : SW'(col) + SW'(ptr_off_i);
  assign ld_idx   = ld_start[IW-1:0];
  assign row_ok   = RW1'(row_full) < RW1'(NUM_PAGES);
  assign sel_ok   = sel_row < RW1'(NUM_PAGES);
  assign start_ok = ld_start < SW'(ROW_BYTES);
  assign do_load  = sel_ok && start_ok && (op_load_i || (rd_fire && rem_q == '0));

  nand_page_array #(
    .NUM_PAGES(NUM_PAGES), .PAGES_PER_BLK(PAGES_PER_BLK), .ROW_BYTES(ROW_BYTES), .PW(PW)
  ) u_array (
    .clk_i, .rst_ni,
    .rd_page_i   (sel_row[PW-1:0]),
    .rd_row_o    (arr_row),
    .prog_en_i   (op_prog_i && row_ok),
    .prog_page_i (row_full[PW-1:0]),
    .prog_row_i  (buf_row),
    .erase_en_i  (op_erase_i && row_ok),
    .erase_page_i(row_full[PW-1:0])
  );

  nand_page_buffer #(.ROW_BYTES(ROW_BYTES), .IW(IW)) u_buffer (
    .clk_i, .rst_ni,
    .clear_i   (op_start_i),
    .load_i    (do_load || (op_copy_i && row_ok)),
    .load_row_i(arr_row),
    .append_i  (din_fire && !any_op && mode_q == FILL_APPEND),
    .col_wr_i  (din_fire && !any_op && mode_q == FILL_COLUMN && SW'(col) < SW'(ROW_BYTES)),
    .col_idx_i (col[IW-1:0]),
    .byte_i    (din_i),
    .buf_o     (buf_row),
    .fill_o    (fill_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= FILL_APPEND;
      seq_q    <= 1'b0;
      rd_row_q <= '0;
      ptr_q    <= '0;
      rem_q    <= '0;
      dout_o   <= IDLE_BYTE;
      done_o   <= 1'b0;
    end else begin
      done_o <= (op_prog_i || op_erase_i) && row_ok;
      if (op_start_i || op_prog_i || op_erase_i || op_copy_i) begin
        rem_q <= '0;
        seq_q <= 1'b0;
        if (op_start_i) mode_q <= FILL_APPEND;
        if (op_copy_i)  mode_q <= FILL_COLUMN;
      end else if (op_load_i) begin
        seq_q <= do_load;
        rem_q <= do_load ? IW'(ROW_BYTES) - ld_idx : '0;
        ptr_q <= ld_idx;
        if (do_load) rd_row_q <= sel_row[ROW_W-1:0];
      end else if (rd_strobe_i) begin
        if (ce_ni) begin
          dout_o <= IDLE_BYTE;
        end else if (rem_q != '0) begin
          dout_o <= buf_row[ptr_q];
          ptr_q  <= ptr_q + 1'b1;
          rem_q  <= rem_q - 1'b1;
        end else if (do_load) begin
          dout_o   <= arr_row[ld_idx];
          ptr_q    <= ld_idx + 1'b1;
          rem_q    <= IW'(ROW_BYTES) - ld_idx - 1'b1;
          rd_row_q <= sel_row[ROW_W-1:0];
          seq_q    <= 1'b1;
        end else begin
          dout_o <= IDLE_BYTE;
        end
      end
    end
  end
endmodule

// File: rtl/nand_page_unit_chk.sv
module nand_page_unit_chk #(
  parameter int ROW_BYTES = 66,
  parameter int IW        = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          rd_strobe_i,
  input logic          any_op,
  input logic          op_prog_i,
  input logic          op_erase_i,
  input logic          done_o,
  input logic [7:0]    dout_o,
  input logic [IW-1:0] rem_q,
  input logic [IW-1:0] fill_cnt
);
  // R5
  done_after_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(op_prog_i || op_erase_i));
  // R8
  ce_high_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && ce_ni && !any_op) |=> dout_o == 8'h00);
  // R8
  ce_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && ce_ni && !any_op) |=> $stable(rem_q));
  // R7
  rem_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !ce_ni && !any_op && rem_q != '0) |=> rem_q == $past(rem_q) - 1'b1);
  // R7
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= IW'(ROW_BYTES));
  // R3
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= IW'(ROW_BYTES));
endmodule

bind nand_page_unit nand_page_unit_chk #(.ROW_BYTES(ROW_BYTES), .IW(IW)) u_chk (
  .clk_i, .rst_ni, .ce_ni, .rd_strobe_i, .any_op, .op_prog_i, .op_erase_i,
  .done_o, .dout_o, .rem_q, .fill_cnt
);

// File: tb/nand_page_unit_test.sv
`timescale 1ns/1ps
module nand_page_unit_test;
  localparam int PAGE = 64;
  localparam int ROW  = PAGE + PAGE / 32;
  localparam int NPG  = 8;
  localparam int PPB  = 4;
  localparam int K_START = 0, K_LOAD = 1, K_PROG = 2, K_COPY = 3, K_ERASE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, dvalid = 1'b0, rd = 1'b0;
  logic [7:0] din = '0;
  logic [23:0] addr = '0;
  logic [15:0] poff = '0;
  logic o_start = 0, o_load = 0, o_prog = 0, o_copy = 0, o_erase = 0;
  logic [7:0] dout;
  logic done;
  int checks = 0, errors = 0;
  logic [7:0] model [NPG][ROW];
  logic [7:0] wbuf [ROW];

  always #2 clk = ~clk;

  nand_page_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .din_valid_i(dvalid), .din_i(din), .rd_strobe_i(rd), .addr_i(addr),
    .ptr_off_i(poff), .op_start_i(o_start), .op_load_i(o_load), .op_prog_i(o_prog),
    .op_copy_i(o_copy), .op_erase_i(o_erase), .dout_o(dout), .done_o(done)
  );

  // read windows: page, column, offset, expected byte count
  localparam int TBL [6][4] = '{
    '{0, 0, 0, 66}, '{1, 10, 0, 56}, '{2, 0, 64, 2},
    '{3, 60, 5, 1}, '{5, 3, 2, 61}, '{2, 0, 0, 66}
  };

  function automatic logic [7:0] pat(int p, int i);
    return 8'(p * 37 + i * 5 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(input int kind, input int row, input int col, input int off);
    addr = {8'(row), 16'(col)};
    poff = 16'(off);
    o_start = kind == K_START; o_load = kind == K_LOAD; o_prog = kind == K_PROG;
    o_copy = kind == K_COPY;   o_erase = kind == K_ERASE;
    @(negedge clk);
    {o_start, o_load, o_prog, o_copy, o_erase} = '0;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic ce);
    ce_n = ce; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; ce_n = 1'b0;
    b = dout;
  endtask

  task automatic put(input logic [7:0] v, input logic c, input logic a, input logic ce, input int col);
    din = v; cle = c; ale = a; ce_n = ce; dvalid = 1'b1;
    addr[15:0] = 16'(col);
    @(negedge clk);
    dvalid = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  // window read compared against the bench model
  task automatic read_win(input int row, input int col, input int off, input int n, input string tag);
    logic [7:0] b;
    int bad = 0, fa = 0, fe = 0;
    op(K_LOAD, row, col, off);
    for (int k = 0; k < n; k++) begin
      rd_byte(b, 1'b0);
      if (b !== model[row][col + off + k]) begin
        if (bad == 0) begin fa = b; fe = model[row][col + off + k]; end
        bad++;
      end
    end
    check(bad == 0, tag, fa, fe);
  endtask

  task automatic commit(input int row, input bit expect_done, input string tag);
    op(K_PROG, row, 0, 0);
    check(done == expect_done, tag, done, expect_done);
    if (expect_done)
      for (int i = 0; i < ROW; i++) model[row][i] = model[row][i] & wbuf[i];
    @(negedge clk);
    check(done == 1'b0, {tag, " pulse"}, done, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    for (int p = 0; p < NPG; p++) for (int i = 0; i < ROW; i++) model[p][i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dout == 8'h00 && done == 1'b0, "R1 outputs", {dout, 7'b0, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_win(3, 0, 0, ROW, "R1 erased array");

    // R3: program pages 0..5, page 2 gets 70 bytes (4 dropped)
    for (int p = 0; p < 6; p++) begin
      op(K_START, 0, 0, 0);
      for (int i = 0; i < ROW; i++) begin wbuf[i] = pat(p, i); put(pat(p, i), 0, 0, 0, 0); end
      if (p == 2) for (int i = 0; i < 4; i++) put(8'h00, 0, 0, 0, 0);
      commit(p, 1'b1, "R5 program done");
    end

    // R7 R9 R12: table of read windows, then one strobe past the window
    foreach (TBL[t]) begin
      int r, s;
      r = TBL[t][0];
      s = TBL[t][1] + TBL[t][2];
      read_win(r, TBL[t][1], TBL[t][2], TBL[t][3], "R7 R12 window");
      check(s + TBL[t][3] == ROW, "R7 count", s + TBL[t][3], ROW);
      rd_byte(b, 1'b0);
      check(b == model[r + 1][0], "R9 next page", b, model[r + 1][0]);
    end

    // R7: start beyond row
    op(K_LOAD, 3, 60, 6);
    rd_byte(b, 1'b0);
    check(b == 8'h00, "R7 start past row", b, 0);

    // R2: last page, full row then idle
    read_win(7, 0, 0, ROW, "R2 last page row");
    rd_byte(b, 1'b0);
    check(b == 8'h00, "R2 idle after last row", b, 0);

    // R8: CE high read does not advance
    op(K_LOAD, 0, 0, 0);
    rd_byte(b, 1'b0);
    check(b == model[0][0], "R8 first byte", b, model[0][0]);
    rd_byte(b, 1'b1);
    check(b == 8'h00, "R8 ce high idle", b, 0);
    rd_byte(b, 1'b0);
    check(b == model[0][1], "R8 no advance", b, model[0][1]);

    // R4: blocked data-in cycles
    op(K_START, 0, 0, 0);
    put(8'h00, 1, 0, 0, 0);
    put(8'h00, 0, 1, 0, 0);
    put(8'h00, 0, 0, 1, 0);
    for (int i = 0; i < ROW; i++) begin wbuf[i] = pat(6, i); put(pat(6, i), 0, 0, 0, 0); end
    commit(6, 1'b1, "R4 program");
    read_win(6, 0, 0, ROW, "R4 blocked bytes ignored");

    // R5: AND semantics
    op(K_START, 0, 0, 0);
    for (int i = 0; i < ROW; i++) begin wbuf[i] = 8'hF0; put(8'hF0, 0, 0, 0, 0); end
    commit(1, 1'b1, "R5 and program");
    read_win(1, 0, 0, ROW, "R5 and result");
    check(model[1][0] == (pat(1, 0) & 8'hF0), "R5 model", model[1][0], pat(1, 0) & 8'hF0);

    // R6: copyback with column edit, out-of-range column ignored
    op(K_COPY, 0, 0, 0);
    for (int i = 0; i < ROW; i++) wbuf[i] = model[0][i];
    wbuf[5] = 8'h3C;
    put(8'h3C, 0, 0, 0, 5);
    put(8'h00, 0, 0, 0, 70);
    commit(7, 1'b1, "R6 copy program");
    read_win(7, 0, 0, ROW, "R6 copyback page");
    check(model[7][5] == 8'h3C, "R6 edited byte", model[7][5], 8'h3C);

    // R10: erase block of page 5 -> pages 4..7
    op(K_ERASE, 5, 0, 0);
    check(done == 1'b1, "R10 erase done", done, 1);
    for (int p = 4; p < 8; p++) for (int i = 0; i < ROW; i++) model[p][i] = 8'hFF;
    @(negedge clk);
    read_win(4, 0, 0, ROW, "R10 page 4 erased");
    read_win(7, 0, 0, ROW, "R10 page 7 erased");
    read_win(3, 0, 0, ROW, "R10 page 3 kept");

    // R11: out-of-range page index
    op(K_START, 0, 0, 0);
    for (int i = 0; i < 4; i++) put(8'h00, 0, 0, 0, 0);
    op(K_PROG, 9, 0, 0);
    check(done == 1'b0, "R11 program ignored", done, 0);
    op(K_ERASE, 12, 0, 0);
    check(done == 1'b0, "R11 erase ignored", done, 0);
    op(K_LOAD, 8, 0, 0);
    rd_byte(b, 1'b0);
    check(b == 8'h00, "R11 read idle", b, 0);
    read_win(3, 0, 0, ROW, "R11 array unchanged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule